// File: doc/BRIEF.md
# PPS Phase Interval Counter

This block measures the phase offset between two one-pulse-per-second signals: a reference pulse and a pulse from a device under test. A fast local clock (nominally 16 MHz) runs a counter while a gate is open. The gate opens on the rising edge of the reference pulse and closes on the rising edge of the device pulse. Once the gate has closed, the count is captured as one sample, the counter is cleared, and the block waits for the next reference edge.

Each captured sample is added to a wider accumulator. After a fixed number of samples, 256 by default, the finished sum is presented with a one-cycle strobe. The host divides this sum by the sample count to get the average phase.

An invert control flips the device pulse before it is used. With it, a device pulse that slightly leads the reference, and so would give a near-full-scale count, can be moved to an interval in the middle of the range. A gate that stays open for the whole counter range makes the count saturate and raises a missing-pulse flag.

Top module: `pps_phase_counter`

## Requirements
- R1: A captured sample equals the number of local clock cycles between the rising edge of the reference input and the next rising edge of the effective device pulse, both measured at the ports.
- R2: The interval counter advances only while the gate is open and holds otherwise. When the gate closes, the count is copied to `sample_o` on the following cycle, `sample_valid_o` pulses high for exactly one cycle, and the counter returns to zero.
- R3: Every 2^LOG2_N captured samples (256 by default), `sum_o` is loaded with their exact total and `sum_valid_o` pulses for one cycle, one cycle after the last `sample_valid_o`. ACC_W is at least CNT_W + LOG2_N, so the sum cannot wrap.
- R4: After `sum_valid_o`, the next window starts from zero with the next captured sample. Each reported sum contains only that window's samples.
- R5: The effective device pulse is `dut_pps_i` XOR `dut_invert_i`. With the invert control at 1, a falling edge of `dut_pps_i` closes the gate.
- R6: If the gate stays open once the counter holds 2^CNT_W - 1, the counter stays at that value and `missing_o` goes to 1.
- R7: `missing_o` returns to 0 in the cycle in which the next sample is captured. A sample captured after saturation reads 2^CNT_W - 1.
- R8: Any change of `dut_invert_i` discards the partial sum and the sample count. The next sum covers only samples captured after the change.
- R9: After synchronous reset, `sample_o`, `sum_o`, `sample_valid_o`, `sum_valid_o` and `missing_o` are all 0.
- R10: A device edge while the gate is closed has no effect: no sample is captured and `sample_o` is unchanged. A reference edge while the gate is open does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local counting clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_pps_i | input | 1 | Reference pulse, asynchronous |
| dut_pps_i | input | 1 | Device-under-test pulse, asynchronous |
| dut_invert_i | input | 1 | Invert the device pulse |
| sample_o | output | CNT_W | Last captured interval count |
| sample_valid_o | output | 1 | One-cycle strobe on a new sample |
| sum_o | output | ACC_W | Sum of the last full window |
| sum_valid_o | output | 1 | One-cycle strobe on a finished sum |
| missing_o | output | 1 | Gate held open past the counter range |

## Verification
The bench builds the block with CNT_W = 8, LOG2_N = 2 and ACC_W = 10. With an 8-bit counter, saturation and the missing-pulse flag are reached within a few hundred cycles rather than sixteen million. With four-sample windows, several complete sums can be observed, along with a window cut short by an invert change and a window that restarts after a sum. The widths keep the no-wrap margin exact: four full-scale samples fit in ten bits.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;

    typedef struct packed {
        logic ref_rise;
        logic dut_rise;
    } edges_t;

    // smallest accumulator width that cannot wrap
    function automatic int unsigned acc_need(input int unsigned cnt_w,
                                             input int unsigned log2_n);
        return cnt_w + log2_n;
    endfunction

endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= async_i[g];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign rise_o[g] = s2_q & ~s3_q;
    end
endmodule

// File: rtl/ppi_gate.sv
module ppi_gate
    import ppi_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  edges_t edges_i,
    output logic   open_o,
    output logic   close_o
);
    gate_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: if (edges_i.ref_rise) state_d = GATE_OPEN;
            GATE_OPEN: if (edges_i.dut_rise) state_d = GATE_IDLE;
            default:   state_d = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= GATE_IDLE;
        else       state_q <= state_d;
    end

    assign open_o  = (state_q == GATE_OPEN);
    assign close_o = open_o & edges_i.dut_rise;

    // R2: a device edge in the open state shuts the gate
    p_gate_close_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (open_o && edges_i.dut_rise) |=> !open_o);
    // R10: a reference edge does not disturb an open gate
    p_ref_ignored_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (open_o && edges_i.ref_rise && !edges_i.dut_rise) |=> open_o);
endmodule

// File: rtl/ppi_interval.sv
module ppi_interval #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             open_i,
    input  logic             close_i,
    output logic [CNT_W-1:0] sample_o,
    output logic             sample_valid_o,
    output logic             missing_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             capture;

    assign capture = !open_i && pend_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q          <= '0;
            pend_q         <= 1'b0;
            sample_o       <= '0;
            sample_valid_o <= 1'b0;
            missing_o      <= 1'b0;
        end else begin
            sample_valid_o <= 1'b0;
            if (open_i) begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                else                  missing_o <= 1'b1;
            end
            if (close_i) pend_q <= 1'b1;
            if (capture) begin
                sample_o       <= cnt_q;
                cnt_q          <= '0;
                pend_q         <= 1'b0;
                sample_valid_o <= 1'b1;
                missing_o      <= 1'b0;
            end
        end
    end

    // R2: counter frozen while the gate is shut and nothing is pending
    p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!open_i && !pend_q) |=> $stable(cnt_q));
    // R2: the sample strobe is a single cycle
    p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_valid_o |=> !sample_valid_o);
    // R6: saturated counter stays at full scale while the gate is open
    p_sat_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (open_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX && missing_o));
    // R7: capture clears the missing-pulse flag
    p_miss_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        capture |=> !missing_o);
endmodule

// File: rtl/ppi_accum.sv
module ppi_accum #(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned LOG2_N = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] sample_i,
    input  logic             sample_valid_i,
    input  logic             invert_i,
    output logic [ACC_W-1:0] sum_o,
    output logic             sum_valid_o
);
    localparam logic [LOG2_N-1:0] LAST = {LOG2_N{1'b1}};

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_next;
    logic [LOG2_N-1:0] n_q;
    logic              inv_q;
    logic              inv_change;

    assign inv_change = (invert_i != inv_q);
    assign acc_next   = acc_q + ACC_W'(sample_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q       <= '0;
            n_q         <= '0;
            inv_q       <= invert_i;
            sum_o       <= '0;
            sum_valid_o <= 1'b0;
        end else begin
            inv_q       <= invert_i;
            sum_valid_o <= 1'b0;
            if (inv_change) begin
                acc_q <= '0;
                n_q   <= '0;
            end else if (sample_valid_i) begin
                if (n_q == LAST) begin
                    sum_o       <= acc_next;
                    sum_valid_o <= 1'b1;
                    acc_q       <= '0;
                    n_q         <= '0;
                end else begin
                    acc_q <= acc_next;
                    n_q   <= n_q + 1'b1;
                end
            end
        end
    end

    // R3: sum strobe lasts one cycle
    p_sum_pulse_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        sum_valid_o |=> !sum_valid_o);
    // R3: a sum is only reported right after a sample
    p_sum_after_sample_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        sum_valid_o |-> $past(sample_valid_i));
    // R4: the window restarts empty after each sum
    p_restart_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        sum_valid_o |-> (acc_q == '0 && n_q == '0));
    // R8: an invert change empties the window
    p_inv_clear_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        inv_change |=> (acc_q == '0 && n_q == '0));
endmodule

// File: rtl/pps_phase_counter.sv
module pps_phase_counter
    import ppi_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned LOG2_N = 8,
    parameter int unsigned ACC_W  = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ref_pps_i,
    input  logic             dut_pps_i,
    input  logic             dut_invert_i,
    output logic [CNT_W-1:0] sample_o,
    output logic             sample_valid_o,
    output logic [ACC_W-1:0] sum_o,
    output logic             sum_valid_o,
    output logic             missing_o
);
    localparam int unsigned ACC_MIN = acc_need(CNT_W, LOG2_N);

    logic [1:0] raw;
    logic [1:0] rise;
    edges_t     edges;
    logic       gate_open, gate_close;

    // R5: polarity select ahead of the synchronizer
    assign raw = {ref_pps_i, dut_pps_i ^ dut_invert_i};

    ppi_sync #(.N(2)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i(raw),
        .rise_o (rise)
    );

    assign edges.ref_rise = rise[1];
    assign edges.dut_rise = rise[0];

    ppi_gate u_gate (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .edges_i(edges),
        .open_o (gate_open),
        .close_o(gate_close)
    );

    ppi_interval #(.CNT_W(CNT_W)) u_interval (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .open_i        (gate_open),
        .close_i       (gate_close),
        .sample_o      (sample_o),
        .sample_valid_o(sample_valid_o),
        .missing_o     (missing_o)
    );

    ppi_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W), .LOG2_N(LOG2_N)) u_accum (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .sample_i      (sample_o),
        .sample_valid_i(sample_valid_o),
        .invert_i      (dut_invert_i),
        .sum_o         (sum_o),
        .sum_valid_o   (sum_valid_o)
    );

    // R3: parameter set must leave headroom for the full window
    if (ACC_W < ACC_MIN) begin : g_bad_width
        p_acc_width_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            !sum_valid_o);
    end

    // R9: outputs quiet in the first cycle after reset
    p_reset_r9: assert property (@(posedge clk_i)
        $fell(rst_i) |-> (!sample_valid_o && !sum_valid_o && !missing_o));
endmodule

// File: tb/tb_pps_phase_counter.sv
module tb_pps_phase_counter;
    localparam int unsigned CW = 8;
    localparam int unsigned LN = 2;
    localparam int unsigned AW = 10;

    logic clk = 1'b0;
    logic rst;
    logic ref_p, dut_p, inv;
    logic [CW-1:0] sample;
    logic          sample_valid;
    logic [AW-1:0] sum;
    logic          sum_valid;
    logic          missing;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pps_phase_counter #(.CNT_W(CW), .LOG2_N(LN), .ACC_W(AW)) dut (
        .clk_i(clk), .rst_i(rst), .ref_pps_i(ref_p), .dut_pps_i(dut_p),
        .dut_invert_i(inv), .sample_o(sample), .sample_valid_o(sample_valid),
        .sum_o(sum), .sum_valid_o(sum_valid), .missing_o(missing)
    );

    localparam int unsigned NV = 8;
    localparam int unsigned D_TAB [NV] = '{10, 20, 30, 40, 3, 1, 100, 250};
    localparam bit          I_TAB [NV] = '{0, 0, 0, 0, 1, 1, 1, 1};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One measurement: reference edge, then device edge d cycles later.
    task automatic measure(input int d, input int wait_extra,
                           output int smp, output bit seen,
                           output bit sv, output int sm, output bit miss_mid);
        seen = 0; sv = 0; sm = 0; smp = 0; miss_mid = 0;
        @(negedge clk); ref_p = 1'b1;
        repeat (d) @(negedge clk);
        if (wait_extra > 0) begin
            repeat (wait_extra) @(negedge clk);
            miss_mid = missing;
        end
        dut_p = ~inv;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i == 3) begin ref_p = 1'b0; dut_p = inv; end
            if (sample_valid && !seen) begin
                seen = 1; smp = int'(sample);
                chk("R7 missing cleared at capture", int'(missing), 0);
                @(negedge clk);
                chk("R2 sample strobe single cycle", int'(sample_valid), 0);
                sv = sum_valid; sm = int'(sum);
                if (i < 3) begin ref_p = 1'b0; dut_p = inv; end
            end
            if (seen && i >= 3) break;
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int smp, sm, acc, nwin;
        bit seen, sv, mm;
        ref_p = 0; dut_p = 0; inv = 0; rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        chk("R9 sample after reset", int'(sample), 0);
        chk("R9 sum after reset", int'(sum), 0);
        chk("R9 sample_valid after reset", int'(sample_valid), 0);
        chk("R9 sum_valid after reset", int'(sum_valid), 0);
        chk("R9 missing after reset", int'(missing), 0);

        // vector table: R1 count, R5 inversion, R3/R4 windows of four
        acc = 0; nwin = 0;
        for (int k = 0; k < NV; k++) begin
            if (inv != I_TAB[k]) begin
                @(negedge clk); inv = I_TAB[k]; dut_p = I_TAB[k];
                repeat (6) @(negedge clk);
            end
            measure(D_TAB[k], 0, smp, seen, sv, sm, mm);
            chk(I_TAB[k] ? "R5 inverted pulse sample" : "R1 interval sample",
                smp, D_TAB[k]);
            acc += D_TAB[k]; nwin++;
            if (nwin == 4) begin
                chk("R3 sum_valid after fourth sample", int'(sv), 1);
                chk("R4 window sum", sm, acc);
                acc = 0; nwin = 0;
            end else begin
                chk("R3 no sum_valid mid window", int'(sv), 0);
            end
        end

        // R10: device edge with gate closed is ignored
        seen = 0;
        @(negedge clk); dut_p = ~inv;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i == 3) dut_p = inv;
            if (sample_valid) seen = 1;
        end
        chk("R10 lone device edge no capture", int'(seen), 0);
        chk("R10 sample unchanged", int'(sample), 250);

        // R8: invert change mid window discards partial sum
        measure(5, 0, smp, seen, sv, sm, mm);
        measure(6, 0, smp, seen, sv, sm, mm);
        @(negedge clk); inv = 0; dut_p = 0;
        repeat (6) @(negedge clk);
        for (int k = 7; k <= 10; k++) begin
            measure(k, 0, smp, seen, sv, sm, mm);
            chk("R1 sample after invert change", smp, k);
        end
        chk("R8 sum_valid after restart", int'(sv), 1);
        chk("R8 partial window discarded", sm, 34);

        // R6/R7: gate held open past full scale
        measure(1, 270, smp, seen, sv, sm, mm);
        chk("R6 missing flag while stuck open", int'(mm), 1);
        chk("R7 saturated sample value", smp, 255);
        chk("R7 missing after capture", int'(missing), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule